// File: doc/BRIEF.md
# Replica Slot Directory with Shared Overflow Sets

This block keeps the tags for a replica store that backs faulty 8-byte memory words. Each entry records the word address of one faulty word. The entry's position in the directory names the replica slot that holds that word's copy. The directory is set-associative. Every primary set has a fixed number of ways and is selected by the low bits of the word address. When a primary set has no free way left, it can link, once, to one set from a small shared pool of overflow sets. The link is an overflow flag plus a pointer. Several primary sets may point at the same overflow set.

During runtime testing the controller issues insert requests, one for each faulty word found. In normal operation it issues lookup requests, which return either the replica slot index or a miss. A request is accepted when `req_valid` and `req_ready` are both high. The block then spends one cycle on each set it visits, and it visits at most the primary set and its linked overflow set. It returns exactly one response pulse.

Slot numbering counts every set in one range. Primary sets are 0 to NUM_SETS-1 and overflow set k is NUM_SETS+k. The slot index is set number × WAYS + way number. The block stores no replica data and detects no faults itself.

Top module: `repl_dir`

## Requirements
- R1: After reset the block is ready. No response is pending, and a lookup of any address misses with `rsp_hit`=0 and `rsp_err`=0.
- R2: An insert whose address is absent takes the lowest free way of the primary set (set = address modulo NUM_SETS). It responds with `rsp_hit`=1 and slot = set×WAYS+way, on the cycle after the accepting edge.
- R3: A lookup of an address held in its primary set responds `rsp_hit`=1 with that entry's slot, one cycle after acceptance.
- R4: A lookup that misses in a primary set with no overflow link responds `rsp_hit`=0 and `rsp_err`=0, one cycle after acceptance.
- R5: An insert into a full primary set that has no link searches the overflow pool. The search starts at a round-robin pointer (reset value 0) and takes the first overflow set that is not full. The block records the link, moves the pointer to the set after the chosen one, and stores the word in the lowest free way of that overflow set. It responds hit with slot (NUM_SETS+k)×WAYS+way, two cycles after acceptance.
- R6: A request that misses in a linked primary set continues into the linked overflow set. The response comes two cycles after acceptance: a hit with the overflow slot, or a miss.
- R7: The round-robin search wraps around. A later link may point at an overflow set already in use by another primary set, and entries from both primary sets then coexist in it.
- R8: An insert that can find no place responds `rsp_hit`=0 and `rsp_err`=1 and changes no state. This happens in two cases. In the first, the linked overflow set is full, and the response comes two cycles after acceptance. In the second, there is no link and every overflow set is full, and the response comes one cycle after acceptance.
- R9: An insert of an address already present returns its existing slot with `rsp_hit`=1 and uses no new way.
- R10: `req_ready` is low from the edge that accepts a request until the edge that registers its response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_insert | input | 1 | 1 = insert, 0 = lookup |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Lookup found, or insert placed/found, the address |
| rsp_err | output | 1 | Insert failed for lack of space |
| rsp_slot | output | SLOT_W | Replica slot index, meaningful when rsp_hit is 1 |

## Verification
The assertions assume three things. Requests arrive only through the ready/valid handshake. A request's address and operation are known values at the accepting edge. NUM_SETS and NUM_OVF are powers of two, so that the set index and the round-robin pointer wrap naturally. The bench waits for `req_ready` before it raises `req_valid`, drives only defined addresses, and drops `req_valid` after each acceptance. It uses four overflow sets, so that wrap-around sharing and full pool exhaustion are both reached within a few hundred requests.

// File: rtl/rad_pkg.sv
package rad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRIM = 2'd1,
        ST_OVF  = 2'd2
    } dir_state_e;

endpackage

// File: rtl/rad_way_match.sv
module rad_way_match #(
    parameter int WAYS   = 6,
    parameter int ADDR_W = 16,
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][ADDR_W-1:0] tag,
    input  logic [ADDR_W-1:0]           addr,
    output logic [WAYS-1:0]             match,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        has_free,
    output logic [WAY_W-1:0]            free_way
);

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_cmp
            assign match[gw] = vld[gw] && (tag[gw] == addr);
        end
    endgenerate

    assign hit      = |match;
    assign has_free = ~&vld;

    // lowest index wins for both searches
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
            end
            if (!vld[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/rad_ovf_alloc.sv
module rad_ovf_alloc #(
    parameter int NUM_OVF = 16,
    parameter int OVF_W   = (NUM_OVF > 1) ? $clog2(NUM_OVF) : 1
) (
    input  logic [NUM_OVF-1:0] full,
    input  logic [OVF_W-1:0]   start,
    output logic               found,
    output logic [OVF_W-1:0]   pick
);

    // first non-full overflow set at or after start, wrapping
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_OVF - 1; i >= 0; i--) begin
            int c;
            c = int'(start) + i;
            if (c >= NUM_OVF) begin
                c = c - NUM_OVF;
            end
            if (!full[c]) begin
                found = 1'b1;
                pick  = OVF_W'(c);
            end
        end
    end

endmodule

// File: rtl/repl_dir.sv
module repl_dir
    import rad_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int WAYS     = 6,
    parameter int NUM_OVF  = 16,
    parameter int ADDR_W   = 16,
    localparam int TOT     = NUM_SETS + NUM_OVF,
    localparam int SLOT_W  = $clog2(TOT * WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_insert,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [SLOT_W-1:0] rsp_slot
);

    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int OVF_W = (NUM_OVF > 1) ? $clog2(NUM_OVF) : 1;
    localparam int TOT_W = $clog2(TOT);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct {
        dir_state_e                        st;
        logic                              ins;
        logic [ADDR_W-1:0]                 addr;
        logic                              rv;
        logic                              rh;
        logic                              re;
        logic [SLOT_W-1:0]                 rs;
        logic [OVF_W-1:0]                  rr;
        logic [TOT-1:0][WAYS-1:0]          vld;
        logic [TOT-1:0][WAYS-1:0][ADDR_W-1:0] tag;
        logic [NUM_SETS-1:0]               lnk;
        logic [NUM_SETS-1:0][OVF_W-1:0]    ptr;
    } dir_t;

    dir_t d, q;

    logic [SET_W-1:0]   pset;
    logic [TOT_W-1:0]   cur_set;
    logic [WAYS-1:0]    cur_match;
    logic               cur_hit;
    logic [WAY_W-1:0]   cur_hit_way;
    logic               cur_has_free;
    logic [WAY_W-1:0]   cur_free_way;
    logic [NUM_OVF-1:0] ovf_full;
    logic               alloc_found;
    logic [OVF_W-1:0]   alloc_pick;

    assign pset    = q.addr[SET_W-1:0];
    assign cur_set = (q.st == ST_OVF) ? (TOT_W'(NUM_SETS) + TOT_W'(q.ptr[pset]))
                                      : TOT_W'(pset);

    rad_way_match #(
        .WAYS   (WAYS),
        .ADDR_W (ADDR_W),
        .WAY_W  (WAY_W)
    ) u_match (
        .vld      (q.vld[cur_set]),
        .tag      (q.tag[cur_set]),
        .addr     (q.addr),
        .match    (cur_match),
        .hit      (cur_hit),
        .hit_way  (cur_hit_way),
        .has_free (cur_has_free),
        .free_way (cur_free_way)
    );

    genvar gk;
    generate
        for (gk = 0; gk < NUM_OVF; gk++) begin : g_full
            assign ovf_full[gk] = &q.vld[NUM_SETS + gk];
        end
    endgenerate

    rad_ovf_alloc #(
        .NUM_OVF (NUM_OVF),
        .OVF_W   (OVF_W)
    ) u_alloc (
        .full  (ovf_full),
        .start (q.rr),
        .found (alloc_found),
        .pick  (alloc_pick)
    );

    function automatic logic [SLOT_W-1:0] slot_of(logic [TOT_W-1:0] s, logic [WAY_W-1:0] w);
        return SLOT_W'(int'(s) * WAYS + int'(w));
    endfunction

    always_comb begin
        d    = q;
        d.rv = 1'b0;
        d.rh = 1'b0;
        d.re = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_PRIM;
                    d.ins  = req_insert;
                    d.addr = req_addr;
                end
            end
            ST_PRIM: begin
                if (cur_hit) begin
                    d.st = ST_IDLE;
                    d.rv = 1'b1;
                    d.rh = 1'b1;
                    d.rs = slot_of(cur_set, cur_hit_way);
                end else if (q.ins && cur_has_free) begin
                    d.vld[cur_set][cur_free_way] = 1'b1;
                    d.tag[cur_set][cur_free_way] = q.addr;
                    d.st = ST_IDLE;
                    d.rv = 1'b1;
                    d.rh = 1'b1;
                    d.rs = slot_of(cur_set, cur_free_way);
                end else if (q.lnk[pset]) begin
                    d.st = ST_OVF;
                end else if (q.ins && alloc_found) begin
                    d.lnk[pset] = 1'b1;
                    d.ptr[pset] = alloc_pick;
                    d.rr        = (int'(alloc_pick) == NUM_OVF - 1) ? '0 : alloc_pick + 1'b1;
                    d.st        = ST_OVF;
                end else begin
                    d.st = ST_IDLE;
                    d.rv = 1'b1;
                    d.re = q.ins;
                end
            end
            ST_OVF: begin
                d.st = ST_IDLE;
                d.rv = 1'b1;
                if (cur_hit) begin
                    d.rh = 1'b1;
                    d.rs = slot_of(cur_set, cur_hit_way);
                end else if (q.ins && cur_has_free) begin
                    d.vld[cur_set][cur_free_way] = 1'b1;
                    d.tag[cur_set][cur_free_way] = q.addr;
                    d.rh = 1'b1;
                    d.rs = slot_of(cur_set, cur_free_way);
                end else begin
                    d.re = q.ins;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.ins  <= 1'b0;
            q.addr <= '0;
            q.rv   <= 1'b0;
            q.rh   <= 1'b0;
            q.re   <= 1'b0;
            q.rs   <= '0;
            q.rr   <= '0;
            q.vld  <= '0;
            q.tag  <= '0;
            q.lnk  <= '0;
            q.ptr  <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rv;
    assign rsp_hit   = q.rh;
    assign rsp_err   = q.re;
    assign rsp_slot  = q.rs;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10

    AST_HIT_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_err)); // R8

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (int'(rsp_slot) < TOT * WAYS)); // R2

    AST_OVF_SLOT_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && $past(q.st == ST_OVF)) |-> (int'(rsp_slot) >= NUM_SETS * WAYS)); // R6

    AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.lnk) & q.lnk) == $past(q.lnk))); // R5

    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> $onehot0(cur_match)); // R9

endmodule

// File: tb/repl_dir_tb.sv
`timescale 1ns/1ps
module repl_dir_tb;

    localparam int NS  = 8;
    localparam int W   = 6;
    localparam int NO  = 4;
    localparam int AW  = 12;
    localparam int TOT = NS + NO;
    localparam int SW  = $clog2(TOT * W);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_insert = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic          rsp_err;
    logic [SW-1:0] rsp_slot;

    always #2 clk = ~clk;

    repl_dir #(.NUM_SETS(NS), .WAYS(W), .NUM_OVF(NO), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_insert(req_insert), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_slot(rsp_slot)
    );

    typedef struct {
        bit     h;
        bit     e;
        int     slot;
        longint due;
        string  tag;
    } exp_t;

    exp_t   sbq[$];
    int     n_vec = 0;
    int     n_bad = 0;
    longint ncyc = 0;
    bit     done = 0;

    // reference model state
    bit            mv [TOT][W];
    logic [AW-1:0] mt [TOT][W];
    bit            ml [NS];
    int            mp [NS];
    int            mrr = 0;

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic scan(input int s, input logic [AW-1:0] a, output int hw, output int fw);
        hw = -1;
        fw = -1;
        for (int w = W - 1; w >= 0; w--) begin
            if (mv[s][w] && mt[s][w] == a) hw = w;
            if (!mv[s][w]) fw = w;
        end
    endtask

    task automatic model(input bit ins, input logic [AW-1:0] a, output exp_t e);
        int s, hw, fw, o;
        s = int'(a) % NS;
        e.h = 0; e.e = 0; e.slot = 0;
        scan(s, a, hw, fw);
        if (hw >= 0) begin
            e.h = 1; e.slot = s * W + hw; e.due = 1;
        end else if (ins && fw >= 0) begin
            mv[s][fw] = 1; mt[s][fw] = a;
            e.h = 1; e.slot = s * W + fw; e.due = 1;
        end else if (ml[s] || ins) begin
            if (!ml[s]) begin
                int k;
                k = -1;
                for (int i = NO - 1; i >= 0; i--) begin
                    int c, h2, f2;
                    c = (mrr + i) % NO;
                    scan(NS + c, a, h2, f2);
                    if (f2 >= 0) k = c;
                end
                if (k < 0) begin
                    e.e = 1; e.due = 1;
                    return;
                end
                ml[s] = 1; mp[s] = k; mrr = (k + 1) % NO;
            end
            o = NS + mp[s];
            scan(o, a, hw, fw);
            e.due = 2;
            if (hw >= 0) begin
                e.h = 1; e.slot = o * W + hw;
            end else if (ins && fw >= 0) begin
                mv[o][fw] = 1; mt[o][fw] = a;
                e.h = 1; e.slot = o * W + fw;
            end else begin
                e.e = ins;
            end
        end else begin
            e.due = 1;
        end
    endtask

    task automatic issue(input bit ins, input logic [AW-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        model(ins, a, e);
        e.due = ncyc + 1 + e.due;
        e.tag = tag;
        sbq.push_back(e);
        req_valid  = 1'b1;
        req_insert = ins;
        req_addr   = a;
        @(negedge clk);
        req_valid = 1'b0;
        n_vec++;
        if (req_ready !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: req_ready got %b expected 0 after accept", req_ready);
        end
    endtask

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sbq.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R1: unexpected response hit=%b err=%b, expected none", rsp_hit, rsp_err);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    n_vec++;
                    if (rsp_hit !== e.h || rsp_err !== e.e || (e.h && int'(rsp_slot) != e.slot)
                        || ncyc != e.due) begin
                        n_bad++;
                        $display("FAIL %s: hit/err/slot/cyc got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                                 e.tag, rsp_hit, rsp_err, rsp_slot, ncyc, e.h, e.e, e.slot, e.due);
                    end
                end
            end else if (sbq.size() > 0 && ncyc > sbq[0].due) begin
                exp_t e;
                e = sbq.pop_front();
                n_vec++; n_bad++;
                $display("FAIL %s: no response got at cyc %0d expected %0d", e.tag, ncyc, e.due);
            end
            if (ncyc > 100000) begin
                done = 1;
                n_bad++;
                $display("FAIL watchdog: cycles got %0d expected under 100000", ncyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        for (int s = 0; s < TOT; s++)
            for (int w = 0; w < W; w++) begin
                mv[s][w] = 0; mt[s][w] = '0;
            end
        for (int s = 0; s < NS; s++) begin
            ml[s] = 0; mp[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: ready/rsp_valid got %b/%b expected 1/0", req_ready, rsp_valid);
        end

        issue(0, 12'h005, "R1");
        issue(1, 12'h010, "R2");
        issue(1, 12'h018, "R2");
        issue(0, 12'h018, "R3");
        issue(0, 12'h010, "R3");
        issue(1, 12'h010, "R9");
        issue(1, 12'h020, "R9");
        issue(0, 12'h020, "R9");
        for (int k = 5; k <= 7; k++) issue(1, AW'(8 * k), "R2");
        issue(0, 12'h040, "R4");
        issue(1, 12'h040, "R5");
        issue(0, 12'h040, "R6");
        issue(0, 12'h048, "R6");
        for (int s = 1; s <= 3; s++)
            for (int k = 0; k <= 6; k++)
                issue(1, AW'(s + 8 * k), (k < 6) ? "R2" : "R5");
        for (int k = 0; k <= 6; k++) issue(1, AW'(4 + 8 * k), (k < 6) ? "R2" : "R7");
        issue(0, AW'(4 + 48), "R7");
        issue(0, 12'h040, "R7");
        for (int k = 9; k <= 12; k++) issue(1, AW'(8 * k), "R8");
        issue(1, AW'(8 * 13), "R8");
        issue(0, AW'(8 * 13), "R8");
        for (int s = 1; s <= 3; s++)
            for (int k = 7; k <= 11; k++)
                issue(1, AW'(s + 8 * k), "R8");
        for (int k = 0; k <= 6; k++) issue(1, AW'(5 + 8 * k), "R8");
        issue(0, AW'(5 + 48), "R8");
        issue(0, AW'(4 + 48), "R7");

        repeat (6) @(negedge clk);
        done = 1;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL R1: pending responses got %0d expected 0", sbq.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule